// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital side of an 8-bit successive-approximation converter. A host reaches it through a small write/read register port. Through that port the host powers it, enables it, picks one of four single-ended input channels and starts conversions. Toward the analog side it drives the channel select, a sample-and-hold control and a trial code for the DAC. It reads back one comparator bit that is high when the input is at or above the DAC output.

A conversion is one sample cycle followed by eight decision cycles, most significant bit first. It ends with the code written into a result register and a completion flag raised. Code 0 stands for ground and the all-ones code for the supply reference. A conversion can be started in three ways: by a software request, by an automatic restart in free-running mode, or by a rising edge on one of four event inputs when triggering is armed. A power-down bit and the enable bit both stop all sequencing. The channel selection is only passed to the analog multiplexer while the converter is enabled.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The result equals the code found by an MSB-first search in which each trial bit is kept when `cmp_i` is 1 (input at or above the trial code) and dropped otherwise; with an ideal comparator the result equals the input code, including 0x00 and 0xFF.
- R2: A conversion accepted at clock edge E0 has its sample phase in the cycle after E0, decides bits 7..0 at edges E2..E9 and completes at E9. Bit 1 of the control register (address 0) reads 1 from E0 until E9 and 0 after it.
- R3: The channel field (address 1, bits 1:0) reaches `ana_chan_o` one clock after it is written, but only while the enable bit (address 0, bit 0) is 1; with enable 0, `ana_chan_o` keeps its value.
- R4: While the power-down bit (address 0, bit 6) is 1, no conversion starts. Setting it during a conversion aborts that conversion without changing the result or the flag.
- R5: With enable 0 the sequencer stays idle: a start request is dropped, a running conversion is aborted, `hold_o` is 0, `dac_code_o` is 0, and the result is unchanged.
- R6: With the free-running bit (address 0, bit 2) set, a new conversion starts at the same edge on which one completes. After the bit is cleared, the conversion in progress finishes and the sequencer goes idle.
- R7: With the trigger-arm bit (address 0, bit 3) set, a rising edge on `trig_i[sel]` starts a conversion. Here `sel` is address 1, bits 5:4. Edges on other inputs, edges while the trigger is not armed, and edges during a conversion are ignored.
- R8: On completion the flag (address 0, bit 4) is set. `irq_o` is high when the flag and the interrupt-enable bit (address 0, bit 5) are both set. Writing 1 to the flag bit clears it, and writing 0 leaves it unchanged.
- R9: `hold_o` is 1 for every cycle of a conversion, from the sample phase through the last decision, and 0 when idle.
- R10: The result register (address 2) keeps its value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| trig_i | input | 4 | Event inputs for armed triggering |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC output |
| ana_chan_o | output | 2 | Channel select to the analog multiplexer |
| hold_o | output | 1 | Sample-and-hold control, high during a conversion |
| dac_code_o | output | DW | Trial code to the DAC |
| irq_o | output | 1 | Conversion-complete interrupt request |

## Verification
The bench sets different voltages on the unselected channels. A design that latched or routed the wrong channel therefore returns a wrong code rather than a lucky match. It aborts conversions through both the power-down bit and the enable bit, and checks that the old result and a clear flag survive; a design that let an aborted search finish would overwrite the result. It fires a trigger edge in the middle of a conversion and an edge on an unselected input, both of which must leave the sequencer idle afterwards. It also stops free-running mode mid-conversion: a design that cut the conversion short, or restarted once more, would show the wrong busy state exactly nine cycles later.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    // register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CHAN = 2'd1;
    localparam logic [1:0] A_RES  = 2'd2;

    // control register bit positions
    localparam int B_EN   = 0;
    localparam int B_GO   = 1;
    localparam int B_FREE = 2;
    localparam int B_TRIG = 3;
    localparam int B_FLAG = 4;
    localparam int B_IE   = 5;
    localparam int B_PWR  = 6;

    // channel register field positions
    localparam int F_CH_LSB = 0;
    localparam int F_TS_LSB = 4;
    localparam int SEL_W    = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    typedef struct packed {
        logic en;
        logic free;
        logic trig_en;
        logic ie;
        logic pwr;
        logic flag;
    } ctrl_t;

endpackage

// File: rtl/sar_adc_trig.sv
module sar_adc_trig #(
    parameter int SELW = 2,
    localparam int NTRIG = 1 << SELW
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NTRIG-1:0] trig_i,
    input  logic [SELW-1:0]  sel_i,
    output logic             rise_o
);
    logic [NTRIG-1:0] prev_d, prev_q;
    logic [NTRIG-1:0] rise;

    for (genvar i = 0; i < NTRIG; i++) begin : g_rise
        assign rise[i] = trig_i[i] & ~prev_q[i];
    end

    always_comb begin
        prev_d = trig_i;
        rise_o = rise[sel_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int DW = 8,
    localparam int IDXW = $clog2(DW)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          allow_i,
    input  logic          launch_i,
    input  logic          free_i,
    input  logic          cmp_i,
    output logic          busy_o,
    output logic [DW-1:0] dac_o,
    output logic          done_o,
    output logic [DW-1:0] result_o
);
    typedef struct packed {
        phase_e          ph;
        logic [IDXW-1:0] idx;
        logic [DW-1:0]   acc;
    } seq_t;

    seq_t s_d, s_q;
    logic [DW-1:0] trial;
    logic [DW-1:0] acc_next;

    always_comb begin
        s_d      = s_q;
        done_o   = 1'b0;
        dac_o    = '0;
        trial    = s_q.acc | ({{(DW-1){1'b0}}, 1'b1} << s_q.idx);
        acc_next = cmp_i ? trial : s_q.acc;
        result_o = acc_next;

        case (s_q.ph)
            PH_IDLE: begin
                if (launch_i) s_d.ph = PH_SAMPLE;
            end
            PH_SAMPLE: begin
                s_d.ph  = PH_DECIDE;
                s_d.idx = IDXW'(DW - 1);
                s_d.acc = '0;
            end
            PH_DECIDE: begin
                dac_o = trial;
                if (s_q.idx == '0) begin
                    done_o  = 1'b1;
                    s_d.acc = '0;
                    s_d.ph  = free_i ? PH_SAMPLE : PH_IDLE;
                end else begin
                    s_d.idx = s_q.idx - 1'b1;
                    s_d.acc = acc_next;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase

        if (!allow_i) begin
            s_d.ph  = PH_IDLE;
            s_d.acc = '0;
            done_o  = 1'b0;
        end

        busy_o = (s_q.ph != PH_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.ph  <= PH_IDLE;
            s_q.idx <= '0;
            s_q.acc <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             done_i,
    input  logic [DW-1:0]    result_i,
    input  logic             busy_i,
    output logic [SEL_W-1:0] mux_o,
    output logic [SEL_W-1:0] tsel_o,
    output logic             start_req_o,
    output logic             trig_en_o,
    output logic             free_o,
    output logic             allow_o,
    output logic             en_o,
    output logic             pwr_o,
    output logic             flag_o,
    output logic [DW-1:0]    result_o,
    output logic [DW-1:0]    rdata_o,
    output logic             irq_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [SEL_W-1:0] chan_sel;
        logic [SEL_W-1:0] tsel;
        logic [SEL_W-1:0] mux;
        logic [DW-1:0]    result;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_chan;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata_i[DW-1:B_PWR+1],
                            wdata_i[F_TS_LSB-1:F_CH_LSB+SEL_W]};

    always_comb begin
        r_d         = r_q;
        wr_ctrl     = wr_i && (addr_i == A_CTRL);
        wr_chan     = wr_i && (addr_i == A_CHAN);
        start_req_o = wr_ctrl && wdata_i[B_GO];

        if (wr_ctrl) begin
            r_d.ctrl.en      = wdata_i[B_EN];
            r_d.ctrl.free    = wdata_i[B_FREE];
            r_d.ctrl.trig_en = wdata_i[B_TRIG];
            r_d.ctrl.ie      = wdata_i[B_IE];
            r_d.ctrl.pwr     = wdata_i[B_PWR];
            if (wdata_i[B_FLAG]) r_d.ctrl.flag = 1'b0;
        end
        if (wr_chan) begin
            r_d.chan_sel = wdata_i[F_CH_LSB +: SEL_W];
            r_d.tsel     = wdata_i[F_TS_LSB +: SEL_W];
        end

        // selection is forwarded only while enabled
        if (r_q.ctrl.en) r_d.mux = r_q.chan_sel;

        // completion wins over a same-cycle clear
        if (done_i) begin
            r_d.ctrl.flag = 1'b1;
            r_d.result    = result_i;
        end

        allow_o   = r_d.ctrl.en & ~r_d.ctrl.pwr;
        free_o    = r_d.ctrl.free;
        trig_en_o = r_d.ctrl.trig_en;
        tsel_o    = r_d.tsel;
        mux_o     = r_q.mux;
        en_o      = r_q.ctrl.en;
        pwr_o     = r_q.ctrl.pwr;
        flag_o    = r_q.ctrl.flag;
        result_o  = r_q.result;
        irq_o     = r_q.ctrl.flag & r_q.ctrl.ie;

        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[B_EN]   = r_q.ctrl.en;
                rdata_o[B_GO]   = busy_i;
                rdata_o[B_FREE] = r_q.ctrl.free;
                rdata_o[B_TRIG] = r_q.ctrl.trig_en;
                rdata_o[B_FLAG] = r_q.ctrl.flag;
                rdata_o[B_IE]   = r_q.ctrl.ie;
                rdata_o[B_PWR]  = r_q.ctrl.pwr;
            end
            A_CHAN: begin
                rdata_o[F_CH_LSB +: SEL_W] = r_q.chan_sel;
                rdata_o[F_TS_LSB +: SEL_W] = r_q.tsel;
            end
            A_RES:   rdata_o = r_q.result;
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [1:0]              addr_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           rdata_o,
    input  logic [(1<<SEL_W)-1:0]   trig_i,
    input  logic                    cmp_i,
    output logic [SEL_W-1:0]        ana_chan_o,
    output logic                    hold_o,
    output logic [DW-1:0]           dac_code_o,
    output logic                    irq_o
);
    logic             start_req_w, trig_en_w, free_w, allow_w;
    logic             en_w, pwr_w, flag_w, busy_w, done_w, rise_w, launch_w;
    logic [SEL_W-1:0] tsel_w;
    logic [DW-1:0]    seq_res_w, result_w;

    sar_adc_regs #(.DW(DW)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .done_i      (done_w),
        .result_i    (seq_res_w),
        .busy_i      (busy_w),
        .mux_o       (ana_chan_o),
        .tsel_o      (tsel_w),
        .start_req_o (start_req_w),
        .trig_en_o   (trig_en_w),
        .free_o      (free_w),
        .allow_o     (allow_w),
        .en_o        (en_w),
        .pwr_o       (pwr_w),
        .flag_o      (flag_w),
        .result_o    (result_w),
        .rdata_o     (rdata_o),
        .irq_o       (irq_o)
    );

    sar_adc_trig #(.SELW(SEL_W)) u_trig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .sel_i  (tsel_w),
        .rise_o (rise_w)
    );

    assign launch_w = start_req_w | (trig_en_w & rise_w);

    sar_adc_seq #(.DW(DW)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .allow_i  (allow_w),
        .launch_i (launch_w),
        .free_i   (free_w),
        .cmp_i    (cmp_i),
        .busy_o   (busy_w),
        .dac_o    (dac_code_o),
        .done_o   (done_w),
        .result_o (seq_res_w)
    );

    assign hold_o = busy_w;
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
    parameter int DW = 8,
    parameter int CW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          en_i,
    input logic          pwr_i,
    input logic          busy_i,
    input logic          flag_i,
    input logic [DW-1:0] result_i,
    input logic [DW-1:0] dac_i,
    input logic [CW-1:0] chan_i
);
    AST_CHAN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(chan_i)); // R3

    AST_PWR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_i |-> !busy_i); // R4

    AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (!busy_i && dac_i == '0)); // R5

    AST_FLAG_FROM_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> $past(busy_i)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_i) |-> $past(busy_i)); // R10
endmodule

bind sar_adc_ctrl sar_adc_chk #(.DW(DW), .CW(sar_adc_pkg::SEL_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .pwr_i    (pwr_w),
    .busy_i   (busy_w),
    .flag_i   (flag_w),
    .result_i (result_w),
    .dac_i    (dac_code_o),
    .chan_i   (ana_chan_o)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
    localparam int DW = 8;
    localparam logic [7:0] C_EN = 8'h01, C_GO = 8'h02, C_FREE = 8'h04, C_TRIG = 8'h08;
    localparam logic [7:0] C_FLAG = 8'h10, C_IE = 8'h20, C_PWR = 8'h40;
    localparam int NVEC = 6;
    // {channel, input code}; the expected result equals the input code
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h80},
        {2'd3, 8'h7F}, {2'd0, 8'h5A}, {2'd2, 8'h01}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [3:0]    trig = 4'd0;
    logic          cmp;
    logic [1:0]    ana_chan;
    logic          hold;
    logic [DW-1:0] dac;
    logic          irq;
    logic [7:0]    vin [4];
    int            n_chk = 0;
    int            n_bad = 0;
    logic [7:0]    rv;
    logic [7:0]    last_res;

    always #5 clk = ~clk;

    assign cmp = (vin[ana_chan] >= dac);

    sar_adc_ctrl #(.DW(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .trig_i(trig), .cmp_i(cmp),
        .ana_chan_o(ana_chan), .hold_o(hold), .dac_code_o(dac), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        trig[idx] = 1'b1;
        @(negedge clk);
        trig[idx] = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 4; k++) vin[k] = 8'h00;
        waitn(3);
        rst_n = 1'b1;
        waitn(1);

        // reset state
        rd(2'd0, rv); check("R5 reset ctrl", rv, 0);
        rd(2'd1, rv); check("R3 reset chan reg", rv, 0);
        rd(2'd2, rv); check("R10 reset result", rv, 0);
        check("R9 reset hold", hold, 0);
        check("R5 reset dac", dac, 0);
        check("R8 reset irq", irq, 0);

        // vector table
        wr(2'd0, C_EN | C_IE);
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 4; k++) vin[k] = VEC[v][7:0] ^ 8'hA5;
            vin[VEC[v][9:8]] = VEC[v][7:0];
            wr(2'd1, {6'd0, VEC[v][9:8]});
            wr(2'd0, C_EN | C_IE | C_GO);
            rd(2'd0, rv); check("R2 busy after start", rv[1], 1);
            check("R9 hold during conversion", hold, 1);
            waitn(8);
            rd(2'd0, rv); check("R2 busy before last decision", rv[1], 1);
            waitn(1);
            rd(2'd0, rv); check("R2 idle after completion", rv[1], 0);
            check("R9 hold released", hold, 0);
            rd(2'd2, rv); check("R1 result code", rv, VEC[v][7:0]);
            check("R3 channel routed", ana_chan, VEC[v][9:8]);
            check("R8 irq on completion", irq, 1);
            wr(2'd0, C_EN | C_IE | C_FLAG);
            check("R8 flag cleared by write one", irq, 0);
        end
        last_res = VEC[NVEC-1][7:0];

        // R10 result persists
        waitn(20);
        rd(2'd2, rv); check("R10 result kept", rv, last_res);

        // R3 channel frozen while disabled
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        waitn(3);
        check("R3 frozen while disabled", ana_chan, 2'd2);
        wr(2'd0, C_EN);
        waitn(1);
        check("R3 forwarded once enabled", ana_chan, 2'd3);

        // R4 power-down blocks start and aborts
        vin[3] = 8'h11;
        wr(2'd0, C_EN | C_PWR | C_GO);
        waitn(1);
        check("R4 no start in power-down", hold, 0);
        waitn(12);
        rd(2'd0, rv); check("R4 no flag in power-down", rv[4], 0);
        wr(2'd0, C_EN | C_GO);
        waitn(3);
        wr(2'd0, C_EN | C_PWR);
        check("R4 abort on power-down", hold, 0);
        waitn(12);
        rd(2'd2, rv); check("R4 result unchanged after abort", rv, last_res);
        rd(2'd0, rv); check("R4 flag clear after abort", rv[4], 0);

        // R5 disable aborts and blocks
        wr(2'd0, C_EN | C_GO);
        waitn(4);
        wr(2'd0, 8'h00);
        check("R5 hold low after disable", hold, 0);
        check("R5 dac zero after disable", dac, 0);
        wr(2'd0, C_GO);
        waitn(1);
        check("R5 start ignored while disabled", hold, 0);
        waitn(12);
        rd(2'd2, rv); check("R5 result unchanged", rv, last_res);
        rd(2'd0, rv); check("R5 no flag while disabled", rv[4], 0);

        // R6 free-running
        vin[3] = 8'h33;
        wr(2'd0, C_EN | C_FREE | C_GO);
        waitn(9);
        rd(2'd0, rv);
        check("R6 first completion flag", rv[4], 1);
        check("R6 restarted at completion", rv[1], 1);
        wr(2'd0, C_EN | C_FREE | C_FLAG);
        rd(2'd0, rv); check("R6 flag cleared", rv[4], 0);
        waitn(8);
        rd(2'd0, rv); check("R6 second completion flag", rv[4], 1);
        wr(2'd0, C_EN);
        rd(2'd0, rv); check("R6 conversion continues after stop", rv[1], 1);
        waitn(8);
        rd(2'd0, rv); check("R6 idle after last conversion", rv[1], 0);
        rd(2'd2, rv); check("R1 free-running result", rv, 8'h33);
        wr(2'd0, C_EN | C_FLAG);

        // R7 armed trigger
        vin[1] = 8'hC3;
        wr(2'd1, 8'h21);
        wr(2'd0, C_EN | C_TRIG | C_IE);
        pulse(1);
        check("R7 unselected input ignored", hold, 0);
        pulse(2);
        check("R7 selected edge starts", hold, 1);
        waitn(3);
        pulse(2);
        waitn(5);
        check("R7 conversion completes", hold, 0);
        rd(2'd2, rv); check("R1 triggered result", rv, 8'hC3);
        check("R8 irq after triggered conversion", irq, 1);
        waitn(3);
        check("R7 edge during conversion ignored", hold, 0);
        wr(2'd0, C_EN | C_IE | C_FLAG);
        pulse(2);
        check("R7 edge ignored when not armed", hold, 0);

        // R8 interrupt gating
        wr(2'd0, C_EN | C_GO);
        waitn(9);
        check("R8 irq masked", irq, 0);
        rd(2'd0, rv); check("R8 flag set while masked", rv[4], 1);
        wr(2'd0, C_EN | C_IE);
        check("R8 irq once enabled, write zero keeps flag", irq, 1);
        wr(2'd0, C_EN | C_IE | C_FLAG);
        check("R8 irq cleared", irq, 0);

        summary();
    end
endmodule